// File: doc/BRIEF.md
# External Bus Write Sequencer

This block turns write requests from on-chip logic into write cycles on an external asynchronous memory bus. A request carries an address, a data word and two byte-lane enables. It is taken on a valid/ready handshake while the sequencer is idle. Each write then runs three timed phases: setup, strobe and hold. Their lengths come from configuration inputs and are counted in clock cycles.

The bus side has these signals:
- a chip-select that is low for the whole access;
- a direction line that is low while the write is under way;
- two active-low write strobes;
- an output-enable that qualifies the data bus.

An external ready pin can stretch the strobe phase, in one of two modes. In direct mode the pin is sampled as it stands. In resynchronized mode it first passes through a two-stage synchronizer, so the pin value used is the one from two cycles earlier. In 32-bit bus mode each strobe serves one half of the word. In 16-bit mode only the low half of the data is driven, and the second strobe pin carries address bit 0.

The configuration and the request fields are captured when the request is accepted. A one-cycle completion pulse follows the end of the hold phase.

Top module: `ext_wr_seq`

## Requirements
- R1: After reset, and whenever no write is in progress, the outputs are at rest: `bus_cs_n`=1, `bus_rnw`=1, `bus_data_oe`=0, `bus_data`=0, `done`=0 and `req_ready`=1.
- R2: When a request is accepted at a clock edge, the cycle that follows is the first setup cycle. After that come `L` setup cycles, then `A`+`W` strobe cycles, then `T` hold cycles, where `W` is the number of wait cycles. `bus_cs_n` is low for exactly those `L`+`A`+`W`+`T` cycles, and the first strobe cycle is cycle `L`+1.
- R3: `done` is high for exactly one cycle: the first idle cycle after the hold phase. `req_ready` is 0 in every cycle in which `bus_cs_n` is low.
- R4: With `cfg_rdy_en`=0 the ready pin is ignored and `W`=0.
- R5: With `cfg_rdy_en`=1 and `cfg_rdy_async`=0, ready is first sampled in strobe cycle `A` (cycle `L`+`A`) and then again in each following cycle. `W` is the number of samples that read 0 before the first sample that reads 1.
- R6: With `cfg_rdy_en`=1 and `cfg_rdy_async`=1, the decision taken in cycle `c` uses the pin value of cycle `c`−2. The first decision is in cycle `L`+`A`, so the first pin sample is effectively at `L`+`A`−2. The write leaves the strobe phase at the first `c` ≥ `L`+`A` whose pin value at `c`−2 was 1.
- R7: In 32-bit mode (`cfg_wide`=1), `bus_we_n[k]` is low during strobe cycles exactly when `req_be[k]` was 1, and is high in every other cycle. `bus_data` carries the full 32-bit word.
- R8: In 16-bit mode (`cfg_wide`=0), `bus_we_n[0]` is low in every strobe cycle whatever the byte enables. `bus_we_n[1]` always equals bit 0 of the captured address, including while idle. `bus_data[31:16]` is 0.
- R9: `bus_addr` changes only at the edge where a request is accepted. It holds the last written address while idle.
- R10: `bus_rnw` is low exactly while `bus_cs_n` is low. `bus_data_oe` is 1 exactly from the first strobe cycle through the last hold cycle, and `bus_data` is 0 whenever `bus_data_oe` is 0.
- R11: A setup, strobe or hold count of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_lead | input | CNT_W | Setup phase length in cycles |
| cfg_active | input | CNT_W | Minimum strobe phase length in cycles |
| cfg_trail | input | CNT_W | Hold phase length in cycles |
| cfg_rdy_en | input | 1 | 1: the ready pin may stretch the strobe phase |
| cfg_rdy_async | input | 1 | 1: the ready pin passes through the synchronizer |
| cfg_wide | input | 1 | 1: 32-bit bus, 0: 16-bit bus |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| req_be | input | 2 | Half-word lane enables for 32-bit mode |
| bus_cs_n | output | 1 | Zone chip-select, active low |
| bus_addr | output | ADDR_W | External address |
| bus_we_n | output | 2 | Write strobes; bit 1 is address bit 0 in 16-bit mode |
| bus_rnw | output | 1 | Direction line, low during a write |
| bus_data | output | DATA_W | External write data |
| bus_data_oe | output | 1 | Data bus drive enable |
| bus_ready | input | 1 | External ready pin |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every bus output is decoded from the phase register. Cycle `c` after the accepting edge therefore shows phase `c` directly: setup in cycles 1..`L`, strobe from `L`+1, and `done` in the cycle after the last hold cycle, carried by one extra flop.

The bench drives the ready pin and samples every output on the falling edge. It numbers the cycles from the accept edge and compares each cycle with the window its requirement predicts. For each test it works out the wait count `W` from its own pin pattern: the first pin cycle at or after `L`+`A` in direct mode, and that index shifted by two in resynchronized mode.

// File: rtl/ews_pkg.sv
package ews_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_LEAD   = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_TRAIL  = 2'd3
  } phase_e;

  // Effective phase length: a programmed zero still lasts one cycle.
  function automatic int unsigned ews_len(input int unsigned n);
    return (n == 0) ? 1 : n;
  endfunction

  // Strobe phase may end when ready is disabled or the selected ready copy is high.
  function automatic logic ews_rdy_ok(input logic en, input logic use_sync,
                                      input logic pin, input logic synced);
    return !en || (use_sync ? synced : pin);
  endfunction

endpackage

// File: rtl/ews_rdy_sync.sv
module ews_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic synced
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[STAGES-2:0], pin};
  end

  assign synced = sr[STAGES-1];
endmodule

// File: rtl/ews_phase_ctrl.sv
module ews_phase_ctrl
  import ews_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] lead,
  input  logic [CNT_W-1:0] active,
  input  logic [CNT_W-1:0] trail,
  input  logic             rdy_ok,
  output phase_e           phase,
  output logic             at_end,
  output logic             done
);
  logic [CNT_W-1:0] cnt, lead_q, act_q, trail_q;
  logic last_lead, last_trail;

  assign last_lead  = (phase == PH_LEAD)   && (cnt == lead_q);
  assign at_end     = (phase == PH_ACTIVE) && (cnt == act_q);
  assign last_trail = (phase == PH_TRAIL)  && (cnt == trail_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      lead_q  <= '0;
      act_q   <= '0;
      trail_q <= '0;
      done    <= 1'b0;
    end else begin
      done <= last_trail;
      unique case (phase)
        PH_IDLE: if (start) begin
          phase   <= PH_LEAD;
          cnt     <= CNT_W'(1);
          lead_q  <= CNT_W'(ews_len(32'(lead)));
          act_q   <= CNT_W'(ews_len(32'(active)));
          trail_q <= CNT_W'(ews_len(32'(trail)));
        end
        PH_LEAD: if (last_lead) begin
          phase <= PH_ACTIVE;
          cnt   <= CNT_W'(1);
        end else cnt <= cnt + 1'b1;
        PH_ACTIVE: if (at_end) begin
          if (rdy_ok) begin
            phase <= PH_TRAIL;
            cnt   <= CNT_W'(1);
          end
        end else cnt <= cnt + 1'b1;
        PH_TRAIL: if (last_trail) begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ews_pin_mux.sv
module ews_pin_mux
  import ews_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  phase_e            phase,
  input  logic              wide,
  input  logic [1:0]        be,
  input  logic              addr_lsb,
  input  logic [DATA_W-1:0] data,
  output logic              cs_n,
  output logic              rnw,
  output logic [1:0]        we_n,
  output logic              oe,
  output logic [DATA_W-1:0] bus_data
);
  localparam int HALF_W = DATA_W / 2;

  logic strobe;
  logic [DATA_W-1:0] shaped;

  assign strobe = (phase == PH_ACTIVE);
  assign cs_n   = (phase == PH_IDLE);
  assign rnw    = (phase == PH_IDLE);
  assign oe     = (phase == PH_ACTIVE) || (phase == PH_TRAIL);

  always_comb begin
    if (wide) begin
      we_n[0] = !(strobe && be[0]);
      we_n[1] = !(strobe && be[1]);
    end else begin
      we_n[0] = !strobe;
      we_n[1] = addr_lsb;
    end
  end

  assign shaped   = wide ? data : {{HALF_W{1'b0}}, data[HALF_W-1:0]};
  assign bus_data = oe ? shaped : '0;
endmodule

// File: rtl/ext_wr_seq.sv
module ext_wr_seq
  import ews_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_lead,
  input  logic [CNT_W-1:0]  cfg_active,
  input  logic [CNT_W-1:0]  cfg_trail,
  input  logic              cfg_rdy_en,
  input  logic              cfg_rdy_async,
  input  logic              cfg_wide,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [1:0]        req_be,
  output logic              bus_cs_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_we_n,
  output logic              bus_rnw,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_data_oe,
  input  logic              bus_ready,
  output logic              done
);
  phase_e phase;
  logic   evt_accept, evt_wait, in_active, at_end, rdy_ok, rdy_synced;
  logic   wide_q, rdy_en_q, rdy_async_q;
  logic [1:0]        be_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign req_ready  = (phase == PH_IDLE);
  assign evt_accept = req_valid && req_ready;
  assign in_active  = (phase == PH_ACTIVE);
  assign rdy_ok     = ews_rdy_ok(rdy_en_q, rdy_async_q, bus_ready, rdy_synced);
  assign evt_wait   = at_end && !rdy_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q      <= '0;
      data_q      <= '0;
      be_q        <= '0;
      wide_q      <= 1'b1;
      rdy_en_q    <= 1'b0;
      rdy_async_q <= 1'b0;
    end else if (evt_accept) begin
      addr_q      <= req_addr;
      data_q      <= req_data;
      be_q        <= req_be;
      wide_q      <= cfg_wide;
      rdy_en_q    <= cfg_rdy_en;
      rdy_async_q <= cfg_rdy_async;
    end
  end

  ews_rdy_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(bus_ready), .synced(rdy_synced)
  );

  ews_phase_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(evt_accept),
    .lead(cfg_lead), .active(cfg_active), .trail(cfg_trail),
    .rdy_ok(rdy_ok), .phase(phase), .at_end(at_end), .done(done)
  );

  ews_pin_mux #(.DATA_W(DATA_W)) u_mux (
    .phase(phase), .wide(wide_q), .be(be_q), .addr_lsb(addr_q[0]),
    .data(data_q), .cs_n(bus_cs_n), .rnw(bus_rnw), .we_n(bus_we_n),
    .oe(bus_data_oe), .bus_data(bus_data)
  );

  assign bus_addr = addr_q;
endmodule

// File: rtl/ext_wr_seq_chk.sv
module ext_wr_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_cs_n,
  input logic              bus_rnw,
  input logic [1:0]        bus_we_n,
  input logic              bus_data_oe,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              req_ready,
  input logic              done,
  input logic              wide_q,
  input logic              evt_wait,
  input logic              in_active,
  input logic              evt_accept
);
  assert_idle_pins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cs_n |-> (bus_rnw && !bus_data_oe));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && bus_cs_n));

  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_accept |=> $stable(bus_addr));

  assert_strobe_in_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_q && (bus_we_n != 2'b11)) |-> !bus_cs_n);

  assert_wait_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wait |=> in_active);

  assert_lead_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> (!bus_cs_n && bus_we_n[0] && !req_ready && !bus_data_oe));
endmodule

bind ext_wr_seq ext_wr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_rnw(bus_rnw),
  .bus_we_n(bus_we_n), .bus_data_oe(bus_data_oe), .bus_addr(bus_addr),
  .req_ready(req_ready), .done(done), .wide_q(wide_q), .evt_wait(evt_wait),
  .in_active(in_active), .evt_accept(evt_accept)
);

// File: tb/ext_wr_seq_bench.sv
module ext_wr_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_lead = '0, cfg_active = '0, cfg_trail = '0;
  logic        cfg_rdy_en = 1'b0, cfg_rdy_async = 1'b0, cfg_wide = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic [1:0]  req_be = '0;
  logic        bus_cs_n, bus_rnw, bus_data_oe, bus_ready = 1'b0, done;
  logic [15:0] bus_addr;
  logic [1:0]  bus_we_n;
  logic [31:0] bus_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_wr_seq u_ext_wr_seq (
    .clk(clk), .rst_n(rst_n), .cfg_lead(cfg_lead), .cfg_active(cfg_active),
    .cfg_trail(cfg_trail), .cfg_rdy_en(cfg_rdy_en), .cfg_rdy_async(cfg_rdy_async),
    .cfg_wide(cfg_wide), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_be(req_be),
    .bus_cs_n(bus_cs_n), .bus_addr(bus_addr), .bus_we_n(bus_we_n),
    .bus_rnw(bus_rnw), .bus_data(bus_data), .bus_data_oe(bus_data_oe),
    .bus_ready(bus_ready), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int eff(input int n);
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // One complete write; rdy_from is the first cycle index with the pin high.
  task automatic run_write(input int l, input int a, input int t, input bit en,
                           input bit async_m, input bit wide, input logic [15:0] addr,
                           input logic [31:0] data, input logic [1:0] be,
                           input int rdy_from, input string wreq);
    int le, ae, te, n, dec, w, busy;
    int n_cs, n_strobe, first_we, done_c, e_we, e_oe, e_data, e_rdy, e_addr, e_rnw;
    logic [1:0]  we_exp;
    logic [31:0] d_exp;
    bit in_strobe, in_oe;
    le = eff(l); ae = eff(a); te = eff(t); n = le + ae;
    dec  = !en ? n : (async_m ? max2(n, rdy_from + 2) : max2(n, rdy_from));
    w    = dec - n;
    busy = le + ae + w + te;
    @(negedge clk);
    cfg_lead = 4'(l); cfg_active = 4'(a); cfg_trail = 4'(t);
    cfg_rdy_en = en; cfg_rdy_async = async_m; cfg_wide = wide;
    bus_ready = (rdy_from <= 0);
    repeat (3) @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_data = data; req_be = be;
    n_cs = 0; n_strobe = 0; first_we = 0; done_c = 0;
    e_we = 0; e_oe = 0; e_data = 0; e_rdy = 0; e_addr = 0; e_rnw = 0;
    for (int c = 1; c <= 200; c++) begin
      @(negedge clk);
      req_valid = 1'b0;
      bus_ready = (c >= rdy_from);
      if (!bus_cs_n) n_cs++;
      in_strobe = (c > le) && (c <= le + ae + w);
      in_oe     = (c > le) && (c <= busy);
      if (wide) we_exp = in_strobe ? ~be : 2'b11;
      else      we_exp = {addr[0], !in_strobe};
      if (bus_we_n != we_exp) e_we++;
      if ((wide ? (bus_we_n != 2'b11) : !bus_we_n[0])) begin
        n_strobe++;
        if (first_we == 0) first_we = c;
      end
      d_exp = in_oe ? (wide ? data : {16'h0, data[15:0]}) : 32'h0;
      if (bus_data_oe != in_oe) e_oe++;
      if (bus_data != d_exp) e_data++;
      if (bus_rnw != bus_cs_n) e_rnw++;
      if (!bus_cs_n && req_ready) e_rdy++;
      if (bus_addr != addr) e_addr++;
      if (done) begin done_c = c; break; end
    end
    chk(n_cs == busy, "R2", "chip-select low cycles", n_cs, busy);
    chk(first_we == le + 1, "R2", "first strobe cycle", first_we, le + 1);
    chk(n_strobe == ae + w, wreq, "strobe cycles incl. waits", n_strobe, ae + w);
    chk(done_c == busy + 1, "R3", "done cycle", done_c, busy + 1);
    chk(e_rdy == 0, "R3", "req_ready high while busy", e_rdy, 0);
    chk(e_we == 0, wide ? "R7" : "R8", "strobe pin pattern mismatches", e_we, 0);
    chk(e_oe == 0 && e_rnw == 0, "R10", "oe/rnw mismatches", e_oe + e_rnw, 0);
    chk(e_data == 0, wide ? "R7" : "R8", "data bus mismatches", e_data, 0);
    chk(e_addr == 0, "R9", "address during access", e_addr, 0);
    @(negedge clk);
    chk(done == 1'b0, "R3", "done single cycle", done, 0);
    repeat (2) @(negedge clk);
    chk(bus_addr == addr, "R9", "address held while idle", bus_addr, addr);
    chk(bus_cs_n && bus_rnw && !bus_data_oe && bus_data == 0 && req_ready, "R1",
        "idle pins after write", {bus_cs_n, bus_rnw, bus_data_oe, req_ready}, 4'b1101);
    if (!wide) chk(bus_we_n[1] == addr[0], "R8", "we1 carries addr bit 0 when idle",
                   bus_we_n[1], addr[0]);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(bus_cs_n && bus_rnw && !bus_data_oe && !done && req_ready && bus_data == 0,
        "R1", "reset pins", {bus_cs_n, bus_rnw, bus_data_oe, done, req_ready}, 5'b11001);
  endtask

  task automatic t_no_ready;   // R4: pin low throughout, still no waits
    run_write(2, 3, 2, 1'b0, 1'b0, 1'b1, 16'h1234, 32'hCAFE_0123, 2'b11, 1000, "R4");
  endtask

  task automatic t_sync_wait;  // R5
    run_write(2, 3, 2, 1'b1, 1'b0, 1'b1, 16'h2222, 32'h1111_2222, 2'b11, 9, "R5");
    run_write(2, 3, 1, 1'b1, 1'b0, 1'b1, 16'h2224, 32'h3333_4444, 2'b11, 0, "R5");
    run_write(3, 3, 1, 1'b1, 1'b0, 1'b1, 16'h2226, 32'h5555_6666, 2'b11, 5, "R5");
  endtask

  task automatic t_async_wait; // R6
    run_write(2, 3, 2, 1'b1, 1'b1, 1'b1, 16'h3330, 32'h7777_8888, 2'b11, 9, "R6");
    run_write(1, 1, 1, 1'b1, 1'b1, 1'b1, 16'h3332, 32'h9999_AAAA, 2'b11, 0, "R6");
    run_write(3, 3, 1, 1'b1, 1'b1, 1'b1, 16'h3334, 32'hBBBB_CCCC, 2'b11, 5, "R6");
  endtask

  task automatic t_narrow;     // R8
    run_write(1, 2, 1, 1'b0, 1'b0, 1'b0, 16'h00A5, 32'hDEAD_BEEF, 2'b00, 1000, "R8");
    run_write(2, 2, 2, 1'b0, 1'b0, 1'b0, 16'h00A4, 32'h1234_5678, 2'b01, 1000, "R8");
  endtask

  task automatic t_byte_lanes; // R7
    run_write(1, 2, 1, 1'b0, 1'b0, 1'b1, 16'h4000, 32'hFACE_B00C, 2'b10, 1000, "R7");
    run_write(1, 2, 1, 1'b0, 1'b0, 1'b1, 16'h4002, 32'h0BAD_F00D, 2'b01, 1000, "R7");
  endtask

  task automatic t_zero;       // R11: zero counts run as one cycle each
    run_write(0, 0, 0, 1'b0, 1'b0, 1'b1, 16'h5555, 32'h0F0F_0F0F, 2'b11, 1000, "R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_no_ready();
    t_sync_wait();
    t_async_wait();
    t_narrow();
    t_byte_lanes();
    t_zero();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule